// File: doc/BRIEF.md
# Parallel Bus Transaction Protocol Monitor

This block sits beside a synchronous, multiplexed parallel bus and drives nothing on it. Every clock it samples the active-low control lines (frame, initiator-ready, target-ready, stop, grant) together with the shared address/data lanes and the shared command/byte-enable lanes. When frame drops low while the bus is idle, the monitor takes that one cycle as the address cycle. It latches the address and the 4-bit command at that point, because neither is valid on the bus later. After that it follows the data phases and counts wait states for both sides of the transfer.

Three kinds of breach raise sticky flags. The first is a target that is too slow to end the first data phase. The second is an initiator that is too slow in any data phase. The third is frame being released while initiator-ready is still deasserted. Beside the flags the monitor holds a code for the first breach seen since the last clear, and the address and command of the transaction in which that breach happened. A counter advances for each transaction that finishes with no breach. The block only observes, so it neither accepts nor applies back-pressure: it keeps up with the bus on every cycle, and its status outputs are plain levels with no handshake.

Top module: `bus_mon`

## Requirements
- R1: A transaction starts on a cycle in which frame is sampled low while the monitor is idle. The address lanes are latched in that cycle only. When a breach is recorded, err_addr shows that latched address.
- R2: The command/byte-enable lanes are latched as the command only in the start cycle, and err_cmd shows that value. Byte-enable values driven during data phases never reach err_cmd.
- R3: If neither target-ready nor stop has been asserted by data cycle 16 of a transaction (cycle 1 is the cycle after the start), err_flags bit 0 is set. A target answer in cycle 16 or earlier sets no flag.
- R4: Each data phase begins on the cycle after the previous phase completes (for the first phase, on the cycle after the start). If initiator-ready has not been asserted by cycle 8 of a phase, err_flags bit 1 is set. A phase completes when initiator-ready is asserted together with target-ready or stop.
- R5: If frame is high while initiator-ready is high during a transaction, err_flags bit 2 is set and the transaction is abandoned, leaving the monitor idle.
- R6: The flags are sticky. err_code records the first breach since reset or the last clear: 1 for target, 2 for initiator, 3 for frame drop, with target above initiator above frame drop when several happen in one cycle. It reads 0 exactly when no flag is set.
- R7: The grant line has no effect on any output at any time, including while a transaction is in progress.
- R8: done_count rises by one, on the edge after the final phase completes with frame high, for each transaction that saw no breach. It never changes on a cycle with frame low.
- R9: A high clear_i zeroes err_flags, err_code, err_addr and err_cmd on the next edge. A breach detected in the same cycle is kept and becomes the new first breach.
- R10: After reset, every output is zero and the monitor is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Frame, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| trdy_n | input | 1 | Target ready, active low |
| stop_n | input | 1 | Target stop, active low |
| gnt_n | input | 1 | Grant, active low; observed only |
| ad | input | ADDR_W | Multiplexed address/data lanes |
| cbe_n | input | CMD_W | Command in the address cycle, byte enables after it |
| clear_i | input | 1 | Clears the error report |
| err_flags | output | 3 | Sticky flags: bit 0 target, bit 1 initiator, bit 2 frame drop |
| err_code | output | 2 | Code of the first breach since clear |
| err_addr | output | ADDR_W | Address of the transaction that held the first breach |
| err_cmd | output | CMD_W | Command of that transaction |
| done_count | output | CNT_W | Count of transactions completed with no breach |

## Verification
If the phase tracker gets out of step with the bus, done_count shows it on the edge that ends the transaction, either missing an increment or adding a stray one. A later start would also latch the wrong address, which err_addr shows at the next breach. A window counter that is off by one moves the flag rise by one cycle at the 16-cycle or 8-cycle limit, so the bench drives answers right at those limits and one cycle past them. A corrupted first-breach record shows up in err_code and err_addr on the edge after the breach.

// File: rtl/bus_mon_pkg.sv
package bus_mon_pkg;
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_DATA = 1'b1
  } phase_e;

  localparam int ERR_N    = 3;
  localparam int ERR_TGT  = 0;
  localparam int ERR_INI  = 1;
  localparam int ERR_DROP = 2;

  typedef enum logic [1:0] {
    EC_NONE = 2'd0,
    EC_TGT  = 2'd1,
    EC_INI  = 2'd2,
    EC_DROP = 2'd3
  } err_code_e;
endpackage

// File: rtl/bm_phase.sv
module bm_phase
  import bus_mon_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CMD_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic              irdy_n,
  input  logic              trdy_n,
  input  logic              stop_n,
  input  logic [ADDR_W-1:0] ad,
  input  logic [CMD_W-1:0]  cbe_n,
  output logic              in_data,
  output logic              start,
  output logic              phase_done,
  output logic              txn_end,
  output logic              drop,
  output logic [ADDR_W-1:0] txn_addr,
  output logic [CMD_W-1:0]  txn_cmd
);
  phase_e st;
  logic   tgt_resp;

  assign tgt_resp   = ~trdy_n | ~stop_n;
  assign in_data    = (st == PH_DATA);
  assign start      = (st == PH_IDLE) & ~frame_n;
  assign phase_done = in_data & ~irdy_n & tgt_resp;
  assign txn_end    = phase_done & frame_n;
  assign drop       = in_data & frame_n & irdy_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= PH_IDLE;
      txn_addr <= '0;
      txn_cmd  <= '0;
    end else if (start) begin
      st       <= PH_DATA;
      txn_addr <= ad;
      txn_cmd  <= cbe_n;
    end else if (txn_end | drop) begin
      st <= PH_IDLE;
    end
  end
endmodule

// File: rtl/bm_window.sv
module bm_window #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic active,
  input  logic hit,
  output logic expire
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;
  logic          met;

  assign expire = active & ~met & ~hit & (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      met <= 1'b0;
    end else if (restart) begin
      cnt <= '0;
      met <= 1'b0;
    end else if (active & ~met) begin
      if (hit | expire) met <= 1'b1;
      else              cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/bm_report.sv
module bm_report
  import bus_mon_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CMD_W  = 4,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              start,
  input  logic              txn_end,
  input  logic              tgt_to,
  input  logic              ini_to,
  input  logic              drop,
  input  logic [ADDR_W-1:0] txn_addr,
  input  logic [CMD_W-1:0]  txn_cmd,
  output logic [ERR_N-1:0]  err_flags,
  output logic [1:0]        err_code,
  output logic [ADDR_W-1:0] err_addr,
  output logic [CMD_W-1:0]  err_cmd,
  output logic [CNT_W-1:0]  done_count
);
  logic [ERR_N-1:0] new_err, base;
  logic             any_new, txn_bad;
  err_code_e        code_n;

  always_comb begin
    new_err           = '0;
    new_err[ERR_TGT]  = tgt_to;
    new_err[ERR_INI]  = ini_to;
    new_err[ERR_DROP] = drop;
  end

  assign any_new = |new_err;
  assign base    = clear_i ? '0 : err_flags;

  always_comb begin
    if (tgt_to)      code_n = EC_TGT;
    else if (ini_to) code_n = EC_INI;
    else if (drop)   code_n = EC_DROP;
    else             code_n = EC_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_flags <= '0;
      err_code  <= 2'd0;
      err_addr  <= '0;
      err_cmd   <= '0;
    end else begin
      err_flags <= base | new_err;
      if (any_new && base == '0) begin
        err_code <= code_n;
        err_addr <= txn_addr;
        err_cmd  <= txn_cmd;
      end else if (clear_i) begin
        err_code <= 2'd0;
        err_addr <= '0;
        err_cmd  <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txn_bad    <= 1'b0;
      done_count <= '0;
    end else begin
      if (start)        txn_bad <= 1'b0;
      else if (any_new) txn_bad <= 1'b1;
      if ((txn_end | drop) && !txn_bad && !any_new)
        done_count <= done_count + 1'b1;
    end
  end
endmodule

// File: rtl/bus_mon.sv
module bus_mon
  import bus_mon_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int CMD_W     = 4,
  parameter int CNT_W     = 16,
  parameter int TGT_LIMIT = 16,
  parameter int INI_LIMIT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic              irdy_n,
  input  logic              trdy_n,
  input  logic              stop_n,
  input  logic              gnt_n,
  input  logic [ADDR_W-1:0] ad,
  input  logic [CMD_W-1:0]  cbe_n,
  input  logic              clear_i,
  output logic [2:0]        err_flags,
  output logic [1:0]        err_code,
  output logic [ADDR_W-1:0] err_addr,
  output logic [CMD_W-1:0]  err_cmd,
  output logic [CNT_W-1:0]  done_count
);
  logic              in_data, start, phase_done, txn_end, drop_err;
  logic              tgt_to, ini_to;
  logic [ADDR_W-1:0] txn_addr;
  logic [CMD_W-1:0]  txn_cmd;

  bm_phase #(.ADDR_W(ADDR_W), .CMD_W(CMD_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .trdy_n(trdy_n), .stop_n(stop_n), .ad(ad), .cbe_n(cbe_n),
    .in_data(in_data), .start(start), .phase_done(phase_done),
    .txn_end(txn_end), .drop(drop_err), .txn_addr(txn_addr), .txn_cmd(txn_cmd)
  );

  // target window: opened by the start, closed by the first target answer
  bm_window #(.LIMIT(TGT_LIMIT)) u_tgt_win (
    .clk(clk), .rst_n(rst_n), .restart(start), .active(in_data),
    .hit(~trdy_n | ~stop_n), .expire(tgt_to)
  );

  // initiator window: reopened after every completed phase
  bm_window #(.LIMIT(INI_LIMIT)) u_ini_win (
    .clk(clk), .rst_n(rst_n), .restart(start | phase_done), .active(in_data),
    .hit(~irdy_n), .expire(ini_to)
  );

  bm_report #(.ADDR_W(ADDR_W), .CMD_W(CMD_W), .CNT_W(CNT_W)) u_report (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .start(start),
    .txn_end(txn_end), .tgt_to(tgt_to), .ini_to(ini_to), .drop(drop_err),
    .txn_addr(txn_addr), .txn_cmd(txn_cmd), .err_flags(err_flags),
    .err_code(err_code), .err_addr(err_addr), .err_cmd(err_cmd),
    .done_count(done_count)
  );
endmodule

// File: rtl/bus_mon_chk.sv
module bus_mon_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_n,
  input logic             irdy_n,
  input logic             trdy_n,
  input logic             stop_n,
  input logic             gnt_n,
  input logic             clear_i,
  input logic [2:0]       err_flags,
  input logic [1:0]       err_code,
  input logic [CNT_W-1:0] done_count,
  input logic             tgt_to,
  input logic             ini_to,
  input logic             drop_err
);
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_i |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

  p_code_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flags == 3'd0) == (err_code == 2'd0));

  p_tgt_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flags[0]) |-> ($past(trdy_n) && $past(stop_n)));

  p_ini_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flags[1]) |-> $past(irdy_n));

  p_drop_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flags[2]) |-> ($past(frame_n) && $past(irdy_n)));

  p_gnt_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(gnt_n) && !clear_i && !frame_n && !irdy_n && (!trdy_n || !stop_n))
      |=> $stable(err_flags));

  p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (done_count == $past(done_count) ||
              done_count == CNT_W'($past(done_count) + 1'b1)));

  p_count_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n |=> (done_count == $past(done_count)));

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_i && !tgt_to && !ini_to && !drop_err) |=> (err_flags == 3'd0));
endmodule

bind bus_mon bus_mon_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
  .trdy_n(trdy_n), .stop_n(stop_n), .gnt_n(gnt_n), .clear_i(clear_i),
  .err_flags(err_flags), .err_code(err_code), .done_count(done_count),
  .tgt_to(tgt_to), .ini_to(ini_to), .drop_err(drop_err)
);

// File: tb/bus_mon_bench.sv
module bus_mon_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_n = 1'b1, irdy_n = 1'b1, trdy_n = 1'b1, stop_n = 1'b1;
  logic        gnt_n = 1'b1, clear_i = 1'b0;
  logic [31:0] ad = '0;
  logic [3:0]  cbe_n = '1;
  logic [2:0]  err_flags;
  logic [1:0]  err_code;
  logic [31:0] err_addr;
  logic [3:0]  err_cmd;
  logic [15:0] done_count;

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  bit rnd_clr = 1'b0;

  // reference model state
  bit          m_busy, m_tdone, m_idone, m_bad;
  int          m_tcyc, m_pcyc;
  logic [31:0] m_addr;
  logic [3:0]  m_cmd;
  logic [2:0]  e_flags;
  logic [1:0]  e_code;
  logic [31:0] e_addr;
  logic [3:0]  e_cmd;
  logic [15:0] e_cnt;
  logic [31:0] last_addr;
  logic [3:0]  last_cmd;

  always #4 clk = ~clk;

  bus_mon u_bus_mon (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .trdy_n(trdy_n), .stop_n(stop_n), .gnt_n(gnt_n), .ad(ad), .cbe_n(cbe_n),
    .clear_i(clear_i), .err_flags(err_flags), .err_code(err_code),
    .err_addr(err_addr), .err_cmd(err_cmd), .done_count(done_count)
  );

  function automatic logic [1:0] first_code(input logic [2:0] nw);
    if (nw[0])      return 2'd1;
    else if (nw[1]) return 2'd2;
    else if (nw[2]) return 2'd3;
    return 2'd0;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle of the expected behaviour, using the inputs now on the bus
  task automatic model();
    logic [2:0] nw;
    logic [2:0] base;
    bit tresp, done;
    nw = 3'b000;
    if (!m_busy) begin
      if (!frame_n) begin
        m_busy = 1; m_addr = ad; m_cmd = cbe_n;
        m_tcyc = 0; m_pcyc = 0; m_tdone = 0; m_idone = 0; m_bad = 0;
      end
    end else begin
      m_tcyc++; m_pcyc++;
      tresp = !trdy_n || !stop_n;
      if (!m_tdone && !tresp && m_tcyc == 16) nw[0] = 1'b1;   // R3
      if (tresp) m_tdone = 1;
      if (!m_idone && irdy_n && m_pcyc == 8) nw[1] = 1'b1;    // R4
      if (!irdy_n) m_idone = 1;
      if (frame_n && irdy_n) nw[2] = 1'b1;                    // R5
      done = !irdy_n && tresp;
      if (nw != 0) m_bad = 1;
      if (nw[2] || (done && frame_n)) begin
        m_busy = 0;
        if (!m_bad) e_cnt++;                                  // R8
      end else if (done) begin
        m_pcyc = 0; m_idone = 0;
      end
    end
    base = clear_i ? 3'b000 : e_flags;
    if (nw != 0 && base == 0) begin
      e_code = first_code(nw); e_addr = m_addr; e_cmd = m_cmd;
    end else if (clear_i) begin
      e_code = 0; e_addr = 0; e_cmd = 0;
    end
    e_flags = base | nw;
  endtask

  task automatic step();
    model();
    @(posedge clk);
    #1;
    check("R3 R4 R5 R9 flags", 64'(err_flags), 64'(e_flags));
    check("R6 code", 64'(err_code), 64'(e_code));
    check("R1 addr", 64'(err_addr), 64'(e_addr));
    check("R2 cmd", 64'(err_cmd), 64'(e_cmd));
    check("R8 count", 64'(done_count), 64'(e_cnt));
    gnt_n = 1'($urandom % 2);   // R7: grant wanders every cycle
    clear_i = rnd_clr ? (($urandom % 24) == 0) : 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      frame_n = 1; irdy_n = 1; trdy_n = 1; stop_n = 1;
      ad = $urandom; cbe_n = 4'hF;
      step();
    end
  endtask

  task automatic run_txn(input int nph, input int iw0, input int tw0,
                         input bit stp, input bit drp);
    last_addr = $urandom; last_cmd = 4'($urandom);
    frame_n = 0; irdy_n = 1; trdy_n = 1; stop_n = 1;
    ad = last_addr; cbe_n = last_cmd;
    step();
    for (int p = 0; p < nph; p++) begin
      int  iw = (p == 0) ? iw0 : int'($urandom % 3);
      int  tw = (p == 0) ? tw0 : int'($urandom % 3);
      bit  last = (p == nph - 1);
      if (last && drp) begin
        frame_n = 1; irdy_n = 1; trdy_n = 1; stop_n = 1;
        ad = $urandom; cbe_n = 4'($urandom);
        step();
        idle(1);
        return;
      end
      for (int c = 0; c < 40; c++) begin
        bit tr = (c >= tw);
        irdy_n  = !(c >= iw);
        trdy_n  = !(tr && !(last && stp));
        stop_n  = !(tr && last && stp);
        frame_n = (last && !irdy_n) ? 1'b1 : 1'b0;
        ad = $urandom; cbe_n = 4'($urandom);   // byte enables, R2
        step();
        if (!irdy_n && tr) break;
      end
    end
    idle(1);
  endtask

  task automatic do_clear();
    frame_n = 1; irdy_n = 1; trdy_n = 1; stop_n = 1;
    clear_i = 1;
    model();
    @(posedge clk);
    #1;
    clear_i = 0;
    check("R9 flags cleared", 64'(err_flags), 64'(e_flags));
    check("R9 code cleared", 64'(err_code), 64'(e_code));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    m_busy = 0; m_bad = 0; m_tdone = 0; m_idone = 0; m_tcyc = 0; m_pcyc = 0;
    m_addr = 0; m_cmd = 0;
    e_flags = 0; e_code = 0; e_addr = 0; e_cmd = 0; e_cnt = 0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1;
    // R10: reset values
    check("R10 flags", 64'(err_flags), 64'd0);
    check("R10 code", 64'(err_code), 64'd0);
    check("R10 addr", 64'(err_addr), 64'd0);
    check("R10 count", 64'(done_count), 64'd0);
    idle(2);

    // R3 R4 boundaries met exactly: target at cycle 16, initiator at cycle 8
    run_txn(2, 7, 15, 0, 0);
    check("R3 limit met", 64'(err_flags), 64'd0);
    check("R8 clean count", 64'(done_count), 64'd1);

    // R7: grant toggles during a clean burst
    run_txn(3, 0, 0, 1, 0);
    check("R7 grant ignored flags", 64'(err_flags), 64'd0);
    check("R7 grant ignored count", 64'(done_count), 64'd2);

    // R3: target one cycle late
    run_txn(1, 0, 16, 0, 0);
    check("R3 late target", 64'(err_flags), 64'd1);
    check("R6 code target", 64'(err_code), 64'd1);
    check("R1 addr captured", 64'(err_addr), 64'(last_addr));
    check("R2 cmd captured", 64'(err_cmd), 64'(last_cmd));
    check("R8 no count on error", 64'(done_count), 64'd2);

    // R4 R6: late initiator, first breach kept
    run_txn(2, 8, 0, 0, 0);
    check("R4 late initiator", 64'(err_flags), 64'd3);
    check("R6 first code kept", 64'(err_code), 64'd1);

    do_clear();
    check("R9 addr cleared", 64'(err_addr), 64'd0);

    // R5: frame dropped before initiator ready
    run_txn(1, 0, 0, 0, 1);
    check("R5 drop flag", 64'(err_flags), 64'd4);
    check("R6 drop code", 64'(err_code), 64'd3);
    check("R8 drop not counted", 64'(done_count), 64'd2);
    do_clear();

    // constrained random traffic with occasional clears
    rnd_clr = 1;
    for (int n = 0; n < 400; n++) begin
      int nph = 1 + int'($urandom % 4);
      int iw  = int'($urandom % 10);
      int tw  = int'($urandom % 19);
      bit stp = ($urandom % 4) == 0;
      bit drp = ($urandom % 10) == 0;
      run_txn(nph, iw, tw, stp, drp);
      if (($urandom % 5) == 0) idle(1 + int'($urandom % 3));
    end
    rnd_clr = 0;
    idle(2);

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule